// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter

A free-running 16-bit up-counter whose count source is chosen by a 3-bit prescaler select. The select gives the bus clock divided by a power of two, from 1 to 64, or rising edges on an external tick pin. Software controls the block through a byte-wide register port with three registers:

- A control byte holding a stop bit, a self-clearing restart bit, an overflow interrupt enable, the sticky overflow flag and the prescaler select.
- The counter high byte.
- The counter low byte.

A read of the high byte captures the low byte in a holding buffer. Software reads the 16-bit value as the high byte and then the low byte, and gets a coherent pair even while the counter keeps running. When the counter wraps it sets a sticky flag, and an interrupt line follows that flag when the enable bit is set.

Register addresses: 0 is control, 1 is the counter high byte, 2 is the counter low byte, 3 reads 0x00. Control bit layout:

| Bit | Field |
|-----|-------|
| 7 | Overflow flag |
| 6 | Overflow enable |
| 5 | Stop |
| 4 | Restart (write-only) |
| 3 | Unused, reads 0 |
| 2:0 | Prescaler select |

Top module: `prescaled_timer16`

## Requirements
- R1: After reset the control byte reads 0x20 (stop set, all other fields 0), both counter bytes read 0x00, and the counter does not advance while stop is set.
- R2: Select values 000 to 110 (control bits 2:0) count the bus clock divided by 2^n. D clock edges after a restart write that leaves stop clear, the counter holds D>>n.
- R3: Select value 111 counts rising edges of `ext_tick` after a two-flop synchronizer. Each rising edge of at least three cycles high and low adds exactly one.
- R4: Reading address 1 returns the live high byte and captures the live low byte. The next read of address 2 returns the captured byte and releases it. With no capture pending, address 2 returns the live low byte.
- R5: Further reads of address 1 while a capture is pending do not change the captured low byte.
- R6: Writing 1 to control bit 4 clears the counter and the prescaler, and counting restarts from 0x0000. Bit 4 always reads 0. The overflow flag is kept when bit 7 is written as 1.
- R7: A write that sets the stop bit (bit 5) freezes the counter. Clearing the stop bit resumes counting from the frozen value.
- R8: A single write with both stop and restart set leaves the counter at 0x0000 for as long as stop remains set.
- R9: A wrap from 0xFFFF to 0x0000 sets the overflow flag (bit 7). The flag stays set until a control write with bit 7 at 0 clears it. Writing bit 7 as 1 does not clear it.
- R10: `irq` is high exactly while the overflow flag and the overflow enable (bit 6) are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on addresses 1 and 2) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| ext_tick | input | 1 | External count source, asynchronous |
| irq | output | 1 | Overflow interrupt request |

## Verification
Every cycle the assertions check four things:
- A restart write zeroes the counter.
- A stopped counter holds its value.
- A wrap sets the overflow flag and returns the count to zero.
- The flag and the captured low byte stay put unless software releases them.

The divide ratios, the external-edge counting, the coherent two-byte read sequence, stop-and-resume and the reset contents depend on counts measured over many cycles or on sequences of accesses. Only the bench scenarios, which compare each read against an edge-counted model, show those.

// File: rtl/prescaled_timer16.sv
module prescaled_timer16 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ext_tick,
  output logic       irq
);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_LO   = 2'd2;
  localparam int         PRE_W  = 7;

  logic [15:0]      cnt;
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] pmask;
  logic [2:0]       psel;
  logic             stop, ovf_en, ovf_flag;
  logic [7:0]       held;
  logic             latched;
  logic [2:0]       ext_sync;
  logic             ext_rise, div_hit, tick;
  logic             ctrl_wr, restart, hi_rd, lo_rd;
  logic             unused_bits;

  assign unused_bits = reg_wdata[3];

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign restart = ctrl_wr && reg_wdata[4];
  assign hi_rd   = reg_rd && (reg_addr == A_HI);
  assign lo_rd   = reg_rd && (reg_addr == A_LO);

  // prescaler tap: all bits below the selected one are ones
  assign pmask    = (PRE_W'(1) << psel) - PRE_W'(1);
  assign div_hit  = &(pre | ~pmask);
  assign ext_rise = ext_sync[1] & ~ext_sync[2];
  assign tick     = !stop && ((psel == 3'b111) ? ext_rise : div_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[1:0], ext_tick};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pre <= '0;
    else if (restart) pre <= '0;
    else if (!stop)   pre <= pre + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= cnt + 16'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop   <= 1'b1;
      ovf_en <= 1'b0;
      psel   <= 3'b000;
    end else if (ctrl_wr) begin
      stop   <= reg_wdata[5];
      ovf_en <= reg_wdata[6];
      psel   <= reg_wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                       ovf_flag <= 1'b0;
    else if (tick && !restart && (cnt == 16'hFFFF))   ovf_flag <= 1'b1;
    else if (ctrl_wr && !reg_wdata[7])                ovf_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= '0;
      latched <= 1'b0;
    end else if (hi_rd && !latched) begin
      held    <= cnt[7:0];
      latched <= 1'b1;
    end else if (lo_rd) begin
      latched <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {ovf_flag, ovf_en, stop, 2'b00, psel};
      A_HI:    reg_rdata = cnt[15:8];
      A_LO:    reg_rdata = latched ? held : cnt[7:0];
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = ovf_flag & ovf_en;

  p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == 16'h0000));

  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !restart) |=> $stable(cnt));

  p_wrap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && cnt == 16'hFFFF) |=> (ovf_flag && cnt == 16'h0000));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ctrl_wr) |=> ovf_flag);

  p_held_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !lo_rd) |=> (latched && $stable(held)));

endmodule

// File: tb/prescaled_timer16_bench.sv
module prescaled_timer16_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ext_tick = 1'b0;
  logic       irq;

  prescaled_timer16 u_prescaled_timer16 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_tick(ext_tick), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t q[$];

  int vectors = 0;
  int miscompares = 0;
  longint edges = 0;
  longint mark = 0;
  longint wr_edge = 0;
  logic [15:0] base = 16'h0;
  logic [7:0] snap = 8'h0;
  bit snap_valid = 1'b0;

  always @(posedge clk) edges <= edges + 1;

  // monitor: compare each read with the queued expectation
  always @(negedge clk) begin
    if (reg_rd) begin
      vectors++;
      if (q.size() == 0) begin
        miscompares++;
        $display("FAIL scoreboard empty actual=%02h expected=none", reg_rdata);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (reg_rdata !== e.val) begin
          miscompares++;
          $display("FAIL %s actual=%02h expected=%02h", e.tag, reg_rdata, e.val);
        end
      end
    end
  end

  task automatic idle(input int k);
    repeat (k) @(posedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = v;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    wr_edge = edges;
  endtask

  // kind 0: fixed value, 1: live high byte, 2: low byte (captured or live)
  task automatic rd(input logic [1:0] a, input int kind, input int n,
                    input logic [7:0] fixed, input string tag);
    exp_t e;
    logic [15:0] live;
    @(posedge clk); #1;
    reg_rd = 1'b1; reg_addr = a;
    live = base + 16'((edges - mark) >> n);
    e.tag = tag;
    if (kind == 1) begin
      e.val = live[15:8];
      if (!snap_valid) begin snap = live[7:0]; snap_valid = 1'b1; end
    end else if (kind == 2) begin
      e.val = snap_valid ? snap : live[7:0];
      snap_valid = 1'b0;
    end else begin
      e.val = fixed;
    end
    q.push_back(e);
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    vectors++;
    if (irq !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  task automatic ext_pulses(input int p);
    for (int i = 0; i < p; i++) begin
      @(posedge clk); #1; ext_tick = 1'b1;
      repeat (3) @(posedge clk);
      #1; ext_tick = 1'b0;
      repeat (3) @(posedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    longint frozen;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset contents, halted counter
    idle(20);
    rd(2'd0, 0, 0, 8'h20, "R1 ctrl after reset");
    rd(2'd1, 0, 0, 8'h00, "R1 high after reset");
    rd(2'd2, 0, 0, 8'h00, "R1 low after reset");
    rd(2'd3, 0, 0, 8'h00, "R1 unused address");
    chk_irq(1'b0, "R1 irq after reset");

    // R6 restart bit reads back 0
    wr_ctrl(8'h10); mark = wr_edge; base = 0;
    rd(2'd0, 0, 0, 8'h00, "R6 restart bit reads 0");

    // R2 each divide ratio
    for (int n = 0; n < 7; n++) begin
      wr_ctrl(8'h10 | 8'(n)); mark = wr_edge; base = 0;
      idle(200 + 13 * n);
      rd(2'd2, 2, n, 8'h00, $sformatf("R2 divide by %0d", 1 << n));
    end

    // R6 restart also clears the prescaler
    wr_ctrl(8'h13); idle(13);
    wr_ctrl(8'h13); mark = wr_edge; base = 0;
    idle(5);
    rd(2'd2, 2, 3, 8'h00, "R6 prescaler cleared by restart");
    idle(11);
    rd(2'd2, 2, 3, 8'h00, "R6 divide by 8 after restart");

    // R3 external source
    wr_ctrl(8'h17);
    ext_pulses(5);
    idle(4);
    rd(2'd2, 0, 0, 8'd5, "R3 external edges counted");
    ext_pulses(3);
    idle(4);
    rd(2'd2, 0, 0, 8'd8, "R3 external edges counted again");

    // R4 R5 coherent read
    wr_ctrl(8'h10); mark = wr_edge; base = 0;
    idle(300);
    rd(2'd1, 1, 0, 8'h00, "R4 high byte read");
    idle(20);
    rd(2'd1, 1, 0, 8'h00, "R5 second high byte read");
    idle(10);
    rd(2'd2, 2, 0, 8'h00, "R5 low byte keeps first capture");
    rd(2'd2, 2, 0, 8'h00, "R4 low byte live after release");

    // R7 stop and resume
    wr_ctrl(8'h10); mark = wr_edge; base = 0;
    idle(50);
    wr_ctrl(8'h20);
    frozen = wr_edge - mark;
    rd(2'd2, 0, 0, 8'(frozen), "R7 counter frozen");
    idle(30);
    rd(2'd2, 0, 0, 8'(frozen), "R7 counter still frozen");
    wr_ctrl(8'h00); mark = wr_edge; base = 16'(frozen);
    idle(9);
    rd(2'd2, 2, 0, 8'h00, "R7 counting resumed");

    // R8 stop with restart parks at zero
    wr_ctrl(8'h31);
    idle(40);
    rd(2'd1, 0, 0, 8'h00, "R8 parked high byte");
    rd(2'd2, 0, 0, 8'h00, "R8 parked low byte");
    snap_valid = 1'b0;

    // R9 R10 overflow
    wr_ctrl(8'h50); mark = wr_edge; base = 0;
    idle(65000);
    rd(2'd0, 0, 0, 8'h40, "R9 no flag before wrap");
    chk_irq(1'b0, "R10 irq low before wrap");
    idle(600);
    rd(2'd0, 0, 0, 8'hC0, "R9 flag set on wrap");
    chk_irq(1'b1, "R10 irq with enable");
    rd(2'd2, 2, 0, 8'h00, "R9 counter wrapped to low value");
    wr_ctrl(8'h90); mark = wr_edge; base = 0;
    rd(2'd0, 0, 0, 8'h80, "R6 restart keeps flag, R9 write 1 keeps it");
    chk_irq(1'b0, "R10 irq low with enable clear");
    wr_ctrl(8'hD0);
    chk_irq(1'b1, "R10 irq back with enable");
    wr_ctrl(8'h40);
    rd(2'd0, 0, 0, 8'h40, "R9 write 0 clears flag");
    chk_irq(1'b0, "R10 irq low after clear");

    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule